// File: doc/BRIEF.md
# Stereo Digital Attenuator with Soft Volume Ramp

This block scales a stereo stream of signed samples by a per-channel attenuation. Each channel has an 8-bit volume code and a mute bit. Code 0x3C is unity gain. Each higher code adds 0.5 dB of attenuation, so the gain halves every twelve codes. Codes at 0xFC and above silence the channel. The gain is built from a twelve-entry mantissa and a right shift that depends on the octave. The scaled product is rounded to nearest and clamped to the sample width.

An applied code is held for each channel and moves toward a target code. The target comes from the volume input and the mute bit. With the ramp off, the applied code follows the target on the next clock. With the ramp on, it moves only on sample strobes. In the exponential mode it moves one code per strobe across the whole range. In the linear mode it moves one code per strobe only in the top 24 dB window, between codes 0x3C and 0x6C, and jumps across the rest of the range. A mute bit set while the ramp is on therefore fades the channel out instead of cutting it. A busy flag per channel shows that the applied code still differs from the target.

Top module: `dvol_ramp`

## Requirements
- R1: With the applied code at 0x3C, every output sample equals its input sample.
- R2: For an applied code c in 0x3C..0xFB, let k = c-0x3C. The output is (x*M[k mod 12] + 2^(s-1)) >> s, using an arithmetic shift, with s = 15 + k div 12 and M[j] = round(32768*2^(-j/12)). The result is clamped to the signed 16-bit range.
- R3: A volume code below 0x3C acts exactly as code 0x3C.
- R4: A volume code of 0xFC or above, or a set mute bit, gives a target of 0xFC. An applied code of 0xFC outputs exact zero.
- R5: With ramp_en low, the applied code equals the target from the clock after the inputs change. This holds whatever expo_en is.
- R6: With ramp_en and expo_en high, each sample strobe moves the applied code one code toward the target. Between strobes the applied code does not change.
- R7: With ramp_en high and expo_en low, on each strobe: moving to a higher code, the code steps by one while below 0x6C and otherwise jumps to the target. Moving to a lower code, it jumps to the larger of the target and 0x6C while above 0x6C, and otherwise steps down by one.
- R8: With ramp_en high, setting a mute bit makes the channel fade toward 0xFC under the rules of R6 or R7. Clearing it fades the channel back in the same way.
- R9: busy_l and busy_r are high exactly while that channel's applied code differs from its target.
- R10: After reset both applied codes are 0xFC. The outputs and out_valid are zero.
- R11: out_valid is high in the cycle after each strobe. The output samples change only then, and they use the applied code that was in force at the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_l_in | input | 16 | Left input sample, signed |
| smp_r_in | input | 16 | Right input sample, signed |
| vol_l | input | 8 | Left volume code |
| vol_r | input | 8 | Right volume code |
| mute_l | input | 1 | Left mute request |
| mute_r | input | 1 | Right mute request |
| ramp_en | input | 1 | Enable gradual level changes |
| expo_en | input | 1 | Exponential (full range) ramp when ramp enabled |
| smp_l_out | output | 16 | Left scaled sample, signed |
| smp_r_out | output | 16 | Right scaled sample, signed |
| out_valid | output | 1 | Output sample strobe |
| busy_l | output | 1 | Left level not yet at target |
| busy_r | output | 1 | Right level not yet at target |

## Verification
The applied code is internal. A wrong value shows up in two places: as a wrong gain on the first output sample that follows the next strobe, and at once in the busy flag. The reference model therefore predicts both every clock. Errors in step size or step direction show as a wrong sample within one strobe. Errors in the point where the linear mode jumps show as a busy flag that clears too early or too late. Errors in rounding and in the mantissa and shift show as a sample that is off by at least one unit.

// File: rtl/dvol_ramp.sv
module dvol_ramp #(
  parameter int DW        = 16,
  parameter int CW        = 8,
  parameter logic [7:0] UNITY     = 8'h3C,
  parameter logic [7:0] LIN_EDGE  = 8'h6C,
  parameter logic [7:0] MUTE_CODE = 8'hFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_l_in,
  input  logic [DW-1:0] smp_r_in,
  input  logic [CW-1:0] vol_l,
  input  logic [CW-1:0] vol_r,
  input  logic          mute_l,
  input  logic          mute_r,
  input  logic          ramp_en,
  input  logic          expo_en,
  output logic [DW-1:0] smp_l_out,
  output logic [DW-1:0] smp_r_out,
  output logic          out_valid,
  output logic          busy_l,
  output logic          busy_r
);
  localparam int MW = 17;
  localparam int PW = DW + MW + 1;
  localparam int FRAC_SH = MW - 2;
  localparam int STEPS = 12;
  localparam logic signed [PW-1:0] SMAX = PW'((1 <<< (DW-1)) - 1);
  localparam logic signed [PW-1:0] SMIN = -PW'(1 <<< (DW-1));

  logic [CW-1:0] vol_v  [2];
  logic          mute_v [2];
  logic [DW-1:0] din_v  [2];
  logic [CW-1:0] tgt    [2];
  logic [CW-1:0] nxt    [2];
  logic [CW-1:0] cur_q  [2];
  logic [DW-1:0] scl    [2];
  logic [DW-1:0] dout_q [2];
  logic          vld_q;

  assign vol_v[0]  = vol_l;
  assign vol_v[1]  = vol_r;
  assign mute_v[0] = mute_l;
  assign mute_v[1] = mute_r;
  assign din_v[0]  = smp_l_in;
  assign din_v[1]  = smp_r_in;

  function automatic logic [MW-1:0] mant_of(input logic [3:0] j);
    case (j)
      4'd0:    mant_of = 17'd32768;
      4'd1:    mant_of = 17'd30929;
      4'd2:    mant_of = 17'd29193;
      4'd3:    mant_of = 17'd27554;
      4'd4:    mant_of = 17'd26008;
      4'd5:    mant_of = 17'd24548;
      4'd6:    mant_of = 17'd23170;
      4'd7:    mant_of = 17'd21870;
      4'd8:    mant_of = 17'd20643;
      4'd9:    mant_of = 17'd19484;
      4'd10:   mant_of = 17'd18390;
      default: mant_of = 17'd17358;
    endcase
  endfunction

  function automatic logic [DW-1:0] scale(input logic [DW-1:0] x, input logic [CW-1:0] code);
    logic [CW-1:0]          idx;
    logic [CW-1:0]          oct;
    logic [3:0]             frac;
    logic [5:0]             sh;
    logic signed [PW-1:0]   xs;
    logic signed [PW-1:0]   ms;
    logic signed [PW-1:0]   p;
    logic signed [PW-1:0]   r;
    idx  = code - UNITY;
    oct  = idx / CW'(STEPS);
    frac = 4'(idx % CW'(STEPS));
    sh   = 6'(oct) + 6'(FRAC_SH);
    xs   = PW'($signed(x));
    ms   = $signed({{(PW-MW){1'b0}}, mant_of(frac)});
    p    = xs * ms;
    r    = (p + (PW'(1) <<< (sh - 6'd1))) >>> sh;
    if (r > SMAX)      scale = SMAX[DW-1:0];
    else if (r < SMIN) scale = SMIN[DW-1:0];
    else               scale = r[DW-1:0];
  endfunction

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      if (mute_v[c] || vol_v[c] >= MUTE_CODE) tgt[c] = MUTE_CODE;
      else if (vol_v[c] < UNITY)              tgt[c] = UNITY;
      else                                    tgt[c] = vol_v[c];
    end
  end

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      nxt[c] = cur_q[c];
      if (!ramp_en) begin
        nxt[c] = tgt[c];
      end else if (smp_valid && cur_q[c] != tgt[c]) begin
        if (expo_en)
          nxt[c] = (cur_q[c] < tgt[c]) ? cur_q[c] + 1'b1 : cur_q[c] - 1'b1;
        else if (cur_q[c] < tgt[c])
          nxt[c] = (cur_q[c] < LIN_EDGE) ? cur_q[c] + 1'b1 : tgt[c];
        else if (cur_q[c] > LIN_EDGE)
          nxt[c] = (tgt[c] > LIN_EDGE) ? tgt[c] : LIN_EDGE;
        else
          nxt[c] = cur_q[c] - 1'b1;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < 2; c++)
      scl[c] = (cur_q[c] >= MUTE_CODE) ? '0 : scale(din_v[c], cur_q[c]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      for (int c = 0; c < 2; c++) begin
        cur_q[c]  <= MUTE_CODE;
        dout_q[c] <= '0;
      end
    end else begin
      vld_q <= smp_valid;
      for (int c = 0; c < 2; c++) begin
        cur_q[c] <= nxt[c];
        if (smp_valid) dout_q[c] <= scl[c];
      end
    end
  end

  assign smp_l_out = dout_q[0];
  assign smp_r_out = dout_q[1];
  assign out_valid = vld_q;
  assign busy_l    = cur_q[0] != tgt[0];
  assign busy_r    = cur_q[1] != tgt[1];
endmodule

module dvol_ramp_chk #(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic          ramp_en,
  input logic          expo_en,
  input logic          out_valid,
  input logic [DW-1:0] smp_l_out,
  input logic [CW-1:0] app_l,
  input logic [CW-1:0] app_r,
  input logic [CW-1:0] tgt_l
);
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !out_valid);
  a_r4_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && app_l >= 8'hFC) |=> smp_l_out == '0);
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && expo_en && smp_valid) |=>
      (app_l == $past(app_l) || app_l == $past(app_l) + 8'd1 || app_l == $past(app_l) - 8'd1));
  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && !smp_valid) |=> $stable(app_r));
  a_r5_direct: assert property (@(posedge clk) disable iff (!rst_n)
    !ramp_en |=> app_l == $past(tgt_l));
  a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
    app_l >= 8'h3C && app_r >= 8'h3C);
endmodule

bind dvol_ramp dvol_ramp_chk #(.DW(DW), .CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .ramp_en(ramp_en),
  .expo_en(expo_en), .out_valid(out_valid), .smp_l_out(smp_l_out),
  .app_l(cur_q[0]), .app_r(cur_q[1]), .tgt_l(tgt[0])
);

// File: tb/dvol_ramp_test.sv
module dvol_ramp_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [15:0] smp_l_in = '0, smp_r_in = '0;
  logic [7:0] vol_l = 8'h3C, vol_r = 8'h3C;
  logic mute_l = 1'b1, mute_r = 1'b1;
  logic ramp_en = 1'b0, expo_en = 1'b0;
  logic [15:0] smp_l_out, smp_r_out;
  logic out_valid, busy_l, busy_r;

  always #2 clk = ~clk;

  dvol_ramp uut (.*);

  int checks = 0, failures = 0;
  string tag = "R10";
  int m_cur [2];
  int e_out [2];
  int e_vld = 0;
  int strobe_div = 2;
  int cyc = 0;

  function automatic int tgt_of(int v, bit m);
    if (m || v >= 'hFC) return 'hFC;
    if (v < 'h3C) return 'h3C;
    return v;
  endfunction

  function automatic int ref_scale(int x, int code);
    longint p, r;
    int k, s, mnt;
    if (code >= 'hFC) return 0;
    k = code - 'h3C;
    mnt = $rtoi(32768.0 * (2.0 ** (-(k % 12) / 12.0)) + 0.5);
    s = 15 + k / 12;
    p = longint'(x) * longint'(mnt);
    r = (p + (longint'(1) <<< (s - 1))) >>> s;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  function automatic int ref_next(int cur, int t, bit ramp, bit expo, bit stb);
    if (!ramp) return t;
    if (!stb || cur == t) return cur;
    if (expo) return (cur < t) ? cur + 1 : cur - 1;
    if (cur < t) return (cur < 'h6C) ? cur + 1 : t;
    if (cur > 'h6C) return (t > 'h6C) ? t : 'h6C;
    return cur - 1;
  endfunction

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", t, cyc, act, exp);
    end
  endtask

  task automatic step();
    int ins [2];
    int t [2];
    bit [7:0] vv [2];
    bit mm [2];
    ins[0] = int'($signed(smp_l_in)); ins[1] = int'($signed(smp_r_in));
    vv[0] = vol_l; vv[1] = vol_r; mm[0] = mute_l; mm[1] = mute_r;
    @(posedge clk);
    cyc++;
    if (!rst_n) begin
      e_vld = 0;
      for (int c = 0; c < 2; c++) begin m_cur[c] = 'hFC; e_out[c] = 0; end
    end else begin
      e_vld = smp_valid;
      for (int c = 0; c < 2; c++) begin
        t[c] = tgt_of(vv[c], mm[c]);
        if (smp_valid) e_out[c] = ref_scale(ins[c], m_cur[c]);
        m_cur[c] = ref_next(m_cur[c], t[c], ramp_en, expo_en, smp_valid);
      end
    end
    @(negedge clk);
    chk("R11 valid", int'(out_valid), e_vld);
    chk({tag, " left"}, int'($signed(smp_l_out)), e_out[0]);
    chk({tag, " right"}, int'($signed(smp_r_out)), e_out[1]);
    chk("R9 busy_l", int'(busy_l), int'(m_cur[0] != tgt_of(vol_l, mute_l)));
    chk("R9 busy_r", int'(busy_r), int'(m_cur[1] != tgt_of(vol_r, mute_r)));
    smp_valid = ((cyc % strobe_div) == 0);
    smp_l_in = 16'($urandom);
    smp_r_in = 16'($urandom);
    if (cyc % 17 == 0) begin smp_l_in = 16'h7FFF; smp_r_in = 16'h8000; end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_cur[0] = 'hFC; m_cur[1] = 'hFC; e_out[0] = 0; e_out[1] = 0;
    @(negedge clk);
    tag = "R10"; run(4);
    rst_n = 1'b1; run(6);
    tag = "R1"; mute_l = 0; mute_r = 0; vol_l = 8'h3C; vol_r = 8'h3C; run(40);
    tag = "R5"; vol_l = 8'h50; vol_r = 8'h90; expo_en = 1; run(10);
    tag = "R2"; vol_l = 8'h3D; vol_r = 8'h48; run(20);
    vol_l = 8'h54; vol_r = 8'hF0; run(20);
    vol_l = 8'hFB; vol_r = 8'h47; run(20);
    tag = "R3"; vol_l = 8'h10; vol_r = 8'h00; run(20);
    tag = "R4"; vol_l = 8'hFE; vol_r = 8'hFC; run(20);
    vol_l = 8'h3C; vol_r = 8'h60; mute_l = 1; run(20);
    tag = "R6"; mute_l = 0; ramp_en = 1; expo_en = 1; vol_l = 8'h90; vol_r = 8'h3C; run(200);
    vol_l = 8'h3C; strobe_div = 3; run(260);
    tag = "R7"; expo_en = 0; strobe_div = 2; vol_l = 8'hFC; vol_r = 8'h80; run(140);
    vol_l = 8'h40; vol_r = 8'h50; run(120);
    vol_l = 8'h6C; run(20);
    tag = "R8"; mute_l = 1; mute_r = 1; run(120);
    mute_r = 0; vol_r = 8'h3C; run(140);
    expo_en = 1; mute_l = 1; mute_r = 1; run(420);
    mute_l = 0; vol_l = 8'h3C; run(420);
    tag = "R10"; rst_n = 0; run(3);
    rst_n = 1; ramp_en = 0; run(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule